// File: doc/BRIEF.md
# Row Run Aggregator and Serial Frame Packer

This block is the second selection stage of a column-parallel hit readout. For every row of the sensor it takes the run descriptors already found by each column group (a count of valid entries, a local start column and a two-bit length code per entry, and an overflow flag per group). It merges them across all groups in ascending group order. It keeps no more than a fixed number of runs for the whole row and writes a row header followed by the kept run words into a frame page.

Two pages alternate. A frame start strobe closes the page being filled by writing a trailer word that holds the frame's total word count. The strobe then switches the write side to the other page, writes a header word carrying a running frame number, and starts draining the closed page on a serial line, MSB first. The next frame can therefore fill one page while the previous one leaves the chip. The default configuration has 18 groups of 64 columns, so there are 1152 columns and an 11-bit global column. Each group holds up to 6 entries, each row keeps at most 9 runs, and each page is 512 words.

Top module: `runpack_aggregator`

## Requirements
- R1: Runs are taken group by group in ascending group order (group 0 first), and within a group in entry order; only entries below that group's count are used. The global column is group × 64 + local column.
- R2: At most 9 runs are kept per row. Runs beyond the ninth in scan order are discarded.
- R3: A row with kept runs produces a row header word {1, ovf, count[3:0], row[9:0]} (bit 15 set), followed by its run words in scan order. The count is the number of kept runs.
- R4: The row header's overflow bit (bit 14) is set when any group's overflow flag is set or when more than 9 runs were offered; otherwise it is clear.
- R5: A row with no valid runs writes nothing, even if a group overflow flag is set.
- R6: A run word is {3'b000, global column[10:0], length code[1:0]}.
- R7: A frame start closes an open frame with a trailer word equal to its total word count, header and trailer included. It then writes a header word holding the frame number, which is 0 for the first frame after reset and increases by one per frame. Pages alternate.
- R8: A closed frame leaves on ser_out one bit per clock, MSB first, in the order its words were written. ser_valid is high for exactly those bits, and ser_out is 0 whenever ser_valid is low.
- R9: Row strobes that arrive before the first frame start are ignored.
- R10: After reset, ser_valid and ser_out are low until a frame has been closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | One-cycle frame boundary strobe |
| row_valid | input | 1 | One-cycle strobe: the group descriptors for row_idx are present |
| row_idx | input | 10 | Row number of the current descriptors |
| grp_cnt | input | 54 | Per-group count of valid entries, 3 bits per group |
| grp_ovf | input | 18 | Per-group overflow flag from the first stage |
| grp_col | input | 648 | Local start column, 6 bits per entry, 6 entries per group |
| grp_len | input | 216 | Length code, 2 bits per entry, 6 entries per group |
| ser_out | output | 1 | Serial frame data, MSB first |
| ser_valid | output | 1 | High while ser_out carries frame bits |

## Verification
The hardest case to reach from the ports is a row that is cut at the cap while earlier groups are full and later groups still offer runs. It has to be checked together with garbage in entries above each group's count, so that both the order and the discarding show. The bench fills the unused entries with pseudo-random values on every row, sweeps uniform counts from 0 to 6 in every group, and adds rows of exactly 9 and exactly 10 runs. A second frame is filled while the first drains, and every serial word is rebuilt and compared with a model of the frame.

// File: rtl/runpack_pkg.sv
package runpack_pkg;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_ROW   = 2'd1,
    W_TRAIL = 2'd2,
    W_HEAD  = 2'd3
  } wr_state_e;

  // run word: spare zeros, global column, length code
  function automatic logic [15:0] run_word(input logic [10:0] col, input logic [1:0] len);
    return {3'b000, col, len};
  endfunction

  // row header: marker bit, overflow, kept count, row number
  function automatic logic [15:0] row_word(input logic [9:0] row, input logic [3:0] n,
                                           input logic ovf);
    return {1'b1, ovf, n, row};
  endfunction

endpackage

// File: rtl/runpack_select.sv
module runpack_select #(
  parameter int NG       = 18,
  parameter int RPG      = 6,
  parameter int CW       = 3,
  parameter int LOC_W    = 6,
  parameter int MAX_RUNS = 9
) (
  input  logic [NG*CW-1:0]        grp_cnt,
  input  logic [NG-1:0]           grp_ovf,
  input  logic [NG*RPG*LOC_W-1:0] grp_col,
  input  logic [NG*RPG*2-1:0]     grp_len,
  output logic [MAX_RUNS-1:0][15:0] words,
  output logic [3:0]              n_kept,
  output logic                    ovf
);
  import runpack_pkg::*;

  localparam int TW = $clog2(NG*RPG+1);
  localparam int IW = $clog2(MAX_RUNS+1);

  logic [TW-1:0] total_c;
  logic [10:0]   gcol_c;

  // single-pass compaction in scan order (R1, R2)
  always_comb begin
    words   = '0;
    total_c = '0;
    gcol_c  = '0;
    for (int g = 0; g < NG; g++) begin
      for (int j = 0; j < RPG; j++) begin
        if (CW'(j) < grp_cnt[g*CW +: CW]) begin
          if (total_c < TW'(MAX_RUNS)) begin
            gcol_c = 11'(g << LOC_W) | 11'(grp_col[(g*RPG+j)*LOC_W +: LOC_W]);
            words[total_c[IW-1:0]] = run_word(gcol_c, grp_len[(g*RPG+j)*2 +: 2]);
          end
          total_c = total_c + TW'(1);
        end
      end
    end
  end

  assign n_kept = (total_c > TW'(MAX_RUNS)) ? 4'(MAX_RUNS) : 4'(total_c);
  assign ovf    = (|grp_ovf) || (total_c > TW'(MAX_RUNS));

endmodule

// File: rtl/runpack_writer.sv
module runpack_writer #(
  parameter int DEPTH    = 512,
  parameter int MAX_RUNS = 9,
  localparam int AW      = $clog2(DEPTH),
  localparam int IW      = $clog2(MAX_RUNS+1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_start,
  input  logic                      row_valid,
  input  logic [9:0]                row_idx,
  input  logic [MAX_RUNS-1:0][15:0] sel_words,
  input  logic [3:0]                sel_n,
  input  logic                      sel_ovf,
  output logic                      we,
  output logic [AW:0]               waddr,
  output logic [15:0]               wdata,
  output logic                      drain_go,
  output logic                      drain_page,
  output logic [AW:0]               drain_len
);
  import runpack_pkg::*;

  wr_state_e                 state_q, state_d;
  logic                      page_q, page_d;
  logic                      open_q, open_d;
  logic [AW-1:0]             addr_q, addr_d;
  logic [15:0]               fcnt_q, fcnt_d;
  logic [IW-1:0]             idx_q, idx_d;
  logic [IW-1:0]             n_q, n_d;
  logic [15:0]               hdr_q, hdr_d;
  logic [MAX_RUNS-1:0][15:0] words_q, words_d;

  always_comb begin
    state_d  = state_q;
    page_d   = page_q;
    open_d   = open_q;
    addr_d   = addr_q;
    fcnt_d   = fcnt_q;
    idx_d    = idx_q;
    n_d      = n_q;
    hdr_d    = hdr_q;
    words_d  = words_q;
    we       = 1'b0;
    wdata    = '0;
    drain_go = 1'b0;
    case (state_q)
      W_IDLE: begin
        if (frame_start) begin
          state_d = open_q ? W_TRAIL : W_HEAD;
        end else if (row_valid && open_q && (sel_n != 4'd0)) begin
          hdr_d   = row_word(row_idx, sel_n, sel_ovf);
          words_d = sel_words;
          n_d     = sel_n[IW-1:0];
          idx_d   = '0;
          state_d = W_ROW;
        end
      end
      W_ROW: begin
        wdata = (idx_q == '0) ? hdr_q : words_q[idx_q - IW'(1)];
        we    = (addr_q != AW'(DEPTH-1));   // last slot kept for the trailer
        if (we) addr_d = addr_q + AW'(1);
        if (idx_q == n_q) state_d = W_IDLE;
        else              idx_d   = idx_q + IW'(1);
      end
      W_TRAIL: begin
        we       = 1'b1;
        wdata    = 16'(addr_q) + 16'd1;
        drain_go = 1'b1;
        page_d   = ~page_q;
        state_d  = W_HEAD;
      end
      default: begin
        we      = 1'b1;
        wdata   = fcnt_q;
        addr_d  = AW'(1);
        fcnt_d  = fcnt_q + 16'd1;
        open_d  = 1'b1;
        state_d = W_IDLE;
      end
    endcase
  end

  assign waddr      = {page_q, (state_q == W_HEAD) ? AW'(0) : addr_q};
  assign drain_page = page_q;
  assign drain_len  = {1'b0, addr_q} + (AW+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      page_q  <= 1'b0;
      open_q  <= 1'b0;
      addr_q  <= '0;
      fcnt_q  <= '0;
      idx_q   <= '0;
      n_q     <= '0;
      hdr_q   <= '0;
      words_q <= '0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      open_q  <= open_d;
      addr_q  <= addr_d;
      fcnt_q  <= fcnt_d;
      idx_q   <= idx_d;
      n_q     <= n_d;
      hdr_q   <= hdr_d;
      words_q <= words_d;
    end
  end

  // frame boundaries are only taken between rows
  assert_fs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> state_q == W_IDLE);

  // closing a frame moves the write side to the other page
  assert_page_swap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == W_TRAIL |=> page_q != $past(page_q));

  // every row header written carries a kept count in 1..MAX_RUNS (also R5)
  assert_hdr_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_ROW && idx_q == '0) |->
      (wdata[15] && wdata[13:10] != 4'd0 && wdata[13:10] <= 4'(MAX_RUNS)));

  // a row strobe with no open frame leaves the writer idle
  assert_closed_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_IDLE && !open_q && row_valid && !frame_start) |=> state_q == W_IDLE);

endmodule

// File: rtl/runpack_mem.sv
module runpack_mem #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        we,
  input  logic [AW:0] waddr,
  input  logic [15:0] wdata,
  input  logic [AW:0] raddr,
  output logic [15:0] rdata
);
  logic [15:0] mem_q [2*DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];

endmodule

// File: rtl/runpack_serializer.sv
module runpack_serializer #(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        go_page,
  input  logic [AW:0] go_len,
  input  logic [15:0] rd_data,
  output logic [AW:0] rd_addr,
  output logic        ser_out,
  output logic        ser_valid
);
  logic          active_q, active_d;
  logic          page_q, page_d;
  logic [AW:0]   len_q, len_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [3:0]    bit_q, bit_d;

  always_comb begin
    active_d = active_q;
    page_d   = page_q;
    len_d    = len_q;
    addr_d   = addr_q;
    bit_d    = bit_q;
    if (go) begin
      active_d = 1'b1;
      page_d   = go_page;
      len_d    = go_len;
      addr_d   = '0;
      bit_d    = '0;
    end else if (active_q) begin
      if (bit_q == 4'd15) begin
        bit_d = '0;
        if ({1'b0, addr_q} == len_q - (AW+1)'(1)) active_d = 1'b0;
        else                                       addr_d   = addr_q + AW'(1);
      end else begin
        bit_d = bit_q + 4'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      page_q   <= 1'b0;
      len_q    <= '0;
      addr_q   <= '0;
      bit_q    <= '0;
    end else begin
      active_q <= active_d;
      page_q   <= page_d;
      len_q    <= len_d;
      addr_q   <= addr_d;
      bit_q    <= bit_d;
    end
  end

  assign rd_addr   = {page_q, addr_q};
  assign ser_out   = active_q & rd_data[4'd15 - bit_q];
  assign ser_valid = active_q;

  // a new frame never starts while the previous one is still leaving
  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !active_q);

  // the drain stops only after the last bit of the last word
  assert_drain_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> ($past(bit_q) == 4'd15 &&
                         {1'b0, $past(addr_q)} == $past(len_q) - (AW+1)'(1)));

endmodule

// File: rtl/runpack_aggregator.sv
module runpack_aggregator #(
  parameter int NG       = 18,
  parameter int RPG      = 6,
  parameter int LOC_W    = 6,
  parameter int MAX_RUNS = 9,
  parameter int DEPTH    = 512,
  localparam int CW      = $clog2(RPG+1),
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      frame_start,
  input  logic                      row_valid,
  input  logic [9:0]                row_idx,
  input  logic [NG*CW-1:0]          grp_cnt,
  input  logic [NG-1:0]             grp_ovf,
  input  logic [NG*RPG*LOC_W-1:0]   grp_col,
  input  logic [NG*RPG*2-1:0]       grp_len,
  output logic                      ser_out,
  output logic                      ser_valid
);
  logic [1:0]                rst_sync_q;
  logic                      rst_n_int;
  logic [MAX_RUNS-1:0][15:0] sel_words;
  logic [3:0]                sel_n;
  logic                      sel_ovf;
  logic                      we;
  logic [AW:0]               waddr;
  logic [15:0]               wdata;
  logic                      drain_go;
  logic                      drain_page;
  logic [AW:0]               drain_len;
  logic [AW:0]               rd_addr;
  logic [15:0]               rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  runpack_select #(.NG(NG), .RPG(RPG), .CW(CW), .LOC_W(LOC_W), .MAX_RUNS(MAX_RUNS)) u_select (
    .grp_cnt (grp_cnt),
    .grp_ovf (grp_ovf),
    .grp_col (grp_col),
    .grp_len (grp_len),
    .words   (sel_words),
    .n_kept  (sel_n),
    .ovf     (sel_ovf)
  );

  runpack_writer #(.DEPTH(DEPTH), .MAX_RUNS(MAX_RUNS)) u_writer (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .frame_start (frame_start),
    .row_valid   (row_valid),
    .row_idx     (row_idx),
    .sel_words   (sel_words),
    .sel_n       (sel_n),
    .sel_ovf     (sel_ovf),
    .we          (we),
    .waddr       (waddr),
    .wdata       (wdata),
    .drain_go    (drain_go),
    .drain_page  (drain_page),
    .drain_len   (drain_len)
  );

  runpack_mem #(.DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  runpack_serializer #(.DEPTH(DEPTH)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .go        (drain_go),
    .go_page   (drain_page),
    .go_len    (drain_len),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .ser_out   (ser_out),
    .ser_valid (ser_valid)
  );

  // writer never touches the page being drained
  assert_page_split_R8: assert property (@(posedge clk) disable iff (!rst_n_int)
    (we && ser_valid) |-> waddr[AW] != rd_addr[AW]);

endmodule

// File: tb/test_runpack_aggregator.sv
module test_runpack_aggregator;

  localparam int NG    = 18;
  localparam int RPG   = 6;
  localparam int LOC_W = 6;
  localparam int MAXR  = 9;
  localparam int CW    = 3;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    frame_start = 1'b0;
  logic                    row_valid = 1'b0;
  logic [9:0]              row_idx = '0;
  logic [NG*CW-1:0]        grp_cnt = '0;
  logic [NG-1:0]           grp_ovf = '0;
  logic [NG*RPG*LOC_W-1:0] grp_col = '0;
  logic [NG*RPG*2-1:0]     grp_len = '0;
  logic                    ser_out;
  logic                    ser_valid;

  runpack_aggregator i_runpack_aggregator (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .row_valid(row_valid),
    .row_idx(row_idx), .grp_cnt(grp_cnt), .grp_ovf(grp_ovf), .grp_col(grp_col),
    .grp_len(grp_len), .ser_out(ser_out), .ser_valid(ser_valid)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int b_cnt [NG];
  bit b_ovf [NG];
  int b_col [NG][RPG];
  int b_len [NG][RPG];

  logic [15:0] exp_w [$];
  string       exp_t [$];
  logic [15:0] fr_w  [$];
  string       fr_t  [$];
  logic [15:0] got_w [$];
  logic [15:0] cur_bits = '0;
  int          nbits = 0;
  int          frame_no = 0;
  logic [31:0] lf = 32'h1d2c_3b4a;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int rnd();
    lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
    return int'(lf[15:0]);
  endfunction

  // clear counts; fill every entry with garbage that must be ignored (R1)
  task automatic clear_groups();
    for (int g = 0; g < NG; g++) begin
      b_cnt[g] = 0;
      b_ovf[g] = 0;
      for (int j = 0; j < RPG; j++) begin
        b_col[g][j] = rnd() % 64;
        b_len[g][j] = rnd() % 4;
      end
    end
  endtask

  task automatic apply_inputs();
    for (int g = 0; g < NG; g++) begin
      grp_cnt[g*CW +: CW] = CW'(b_cnt[g]);
      grp_ovf[g]          = b_ovf[g];
      for (int j = 0; j < RPG; j++) begin
        grp_col[(g*RPG+j)*LOC_W +: LOC_W] = LOC_W'(b_col[g][j]);
        grp_len[(g*RPG+j)*2 +: 2]         = 2'(b_len[g][j]);
      end
    end
  endtask

  // bench model of one row, appended to the open frame
  task automatic model_row(input int row);
    logic [15:0] runs [$];
    int  total = 0;
    bit  anyovf = 0;
    for (int g = 0; g < NG; g++) begin
      if (b_ovf[g]) anyovf = 1;
      for (int j = 0; j < b_cnt[g]; j++) begin
        if (total < MAXR)
          runs.push_back({3'b000, 11'(g*64 + b_col[g][j]), 2'(b_len[g][j])});
        total++;
      end
    end
    if (runs.size() > 0) begin
      fr_w.push_back({1'b1, (anyovf || total > MAXR), 4'(runs.size()), 10'(row)});
      fr_t.push_back("R3 R4 R5");
      foreach (runs[k]) begin
        fr_w.push_back(runs[k]);
        fr_t.push_back("R1 R2 R6");
      end
    end
  endtask

  task automatic send_row(input int row, input bit frame_open);
    apply_inputs();
    if (frame_open) model_row(row);
    @(negedge clk);
    row_idx   = 10'(row);
    row_valid = 1'b1;
    @(negedge clk);
    row_valid = 1'b0;
    repeat (MAXR + 3) @(negedge clk);
  endtask

  task automatic wait_drain();
    while (ser_valid) @(negedge clk);
  endtask

  task automatic new_frame(input bit closing);
    wait_drain();
    if (closing) begin
      fr_w.push_back(16'(fr_w.size() + 1));
      fr_t.push_back("R7 trailer");
      foreach (fr_w[k]) begin
        exp_w.push_back(fr_w[k]);
        exp_t.push_back(fr_t[k]);
      end
    end
    fr_w.delete();
    fr_t.delete();
    fr_w.push_back(16'(frame_no));
    fr_t.push_back("R7 R9 header");
    frame_no++;
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // rebuild words from the serial line, MSB first (R8)
  always @(negedge clk) begin
    if (ser_valid) begin
      cur_bits = {cur_bits[14:0], ser_out};
      nbits++;
      if (nbits == 16) begin
        got_w.push_back(cur_bits);
        nbits = 0;
      end
    end else begin
      if (ser_out !== 1'b0) check(1'b0, "R8 idle line", int'(ser_out), 0);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ser_valid == 1'b0, "R10 in reset", int'(ser_valid), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(ser_valid == 1'b0 && ser_out == 1'b0, "R10 after reset",
          int'({ser_valid, ser_out}), 0);

    // R9: a row before any frame start is dropped
    clear_groups();
    b_cnt[0] = 3;
    send_row(1, 1'b0);
    check(ser_valid == 1'b0, "R9 no output", int'(ser_valid), 0);

    // frame 0: directed corners plus pseudo-random rows
    new_frame(1'b0);
    clear_groups();                               send_row(5, 1'b1);  // R5 empty
    clear_groups(); b_ovf[3] = 1;                 send_row(6, 1'b1);  // R5 overflow only
    clear_groups(); b_cnt[0] = 2; b_cnt[17] = 2;
    b_col[17][1] = 63;                            send_row(7, 1'b1);  // R1 edges
    clear_groups(); b_cnt[2] = 6; b_cnt[9] = 3;   send_row(8, 1'b1);  // R2 exactly 9
    clear_groups(); b_cnt[1] = 6; b_cnt[5] = 4;   send_row(9, 1'b1);  // R2 R4 ten
    clear_groups(); b_cnt[4] = 2; b_ovf[4] = 1;   send_row(10, 1'b1); // R4 group flag
    for (int r = 0; r < 24; r++) begin
      clear_groups();
      for (int g = 0; g < NG; g++) begin
        if (rnd() % 8 > 5) b_cnt[g] = rnd() % 4;
        b_ovf[g] = (rnd() % 16 == 0);
      end
      send_row(100 + r * 19, 1'b1);
    end

    // frame 1 fills while frame 0 drains: sweep groups and counts
    new_frame(1'b1);
    for (int g = 0; g < NG; g++) begin
      for (int e = 0; e < 2; e++) begin
        clear_groups();
        b_cnt[g] = 1;
        b_col[g][0] = e ? 63 : 0;
        b_len[g][0] = (g + e) % 4;
        send_row(200 + g * 2 + e, 1'b1);
      end
    end
    for (int k = 0; k <= RPG; k++) begin
      clear_groups();
      for (int g = 0; g < NG; g++) b_cnt[g] = k;
      send_row(575 - k, 1'b1);
    end
    new_frame(1'b1);
    wait_drain();
    repeat (4) @(negedge clk);

    check(got_w.size() == exp_w.size() && nbits == 0, "R8 R5 word count",
          got_w.size(), exp_w.size());
    foreach (exp_w[k]) begin
      if (k < got_w.size())
        check(got_w[k] == exp_w[k], $sformatf("%s word %0d", exp_t[k], k),
              int'(got_w[k]), int'(exp_w[k]));
    end
    finish_run();
  end

endmodule